// File: doc/BRIEF.md
# Coherent Table-Entry Update Unit

This unit lets software change one entry of a cached table without losing a concurrent update made by another agent. Each entry is four 64-bit words, addressed by a block number and an offset within the block. Software first writes a selection register that names the entry and picks the watch mode. A read of data word 0 copies the entry's current contents into a four-word staging buffer and arms the watch. Software then writes the words it wants to change into staging. A write to data word 0 carries the new word 0 and commits the whole staged entry to the store.

In full mode, the unit records any write by another agent to the watched entry between the arming read and the commit. Such a commit is dropped, and the status read shows both the full flag and the conflict flag set, so software repeats the whole sequence. Light mode does no conflict tracking and always applies a valid commit. The store is a behavioural model: a backing array that is reset to zero, a small direct-mapped cache with a fill on load and invalidation on write, and an injection port that stands in for the competing writers.

Top module: `entry_watch_top`

## Requirements
- R1: After reset, a status read returns all zeros, and every entry of the store reads as zero.
- R2: Word address 0 is the selection/status register. Writing it stores the block number from bits 35:32, the offset from bits 23:0 and the full-mode flag from bit 55. A read returns those fields at the same positions, with the conflict flag in bit 63 and zeros elsewhere.
- R3: Word addresses 1 to 4 are data words 0 to 3. A read of word 0 loads the selected entry into staging, arms the watch and returns word 0 on regRdata in the cycle after the request. A read of words 1 to 3 returns the staged word in the cycle after the request.
- R4: Writes to data words 1 to 3 change staging only. The stored entry is unchanged until a commit.
- R5: A write to data word 0 on an armed, conflict-free watch stores the staged words 1 to 3 and the written value as word 0, and leaves the conflict flag clear.
- R6: In full mode, an injected write to the watched entry while the watch is armed sets the conflict flag. The following commit is discarded, and the entry keeps only the injected change.
- R7: In light mode, injected writes do not set the conflict flag and a commit is applied. Words that were injected after the load are overwritten by the staged values.
- R8: A commit with no prior load, or one whose block is 4 or more or whose offset is 8 or more (default sizes), is ignored and sets the conflict flag. A data-word-0 read of such an entry returns zero.
- R9: Writing the selection register clears the conflict flag, disarms the watch and sets every staged word to zero.
- R10: An injected write to an entry other than the watched one raises no conflict and changes only that other entry.
- R11: A commit ends the watch. A second data-word-0 write that has no new load is ignored and sets the conflict flag.
- R12: Two entries that share a cache slot each read back their own contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 3 | Word address: 0 selection/status, 1..4 data words 0..3 |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data, valid the cycle after a read request |
| injWe | input | 1 | Competing-writer write strobe |
| injBlock | input | 4 | Competing-writer block number |
| injOffs | input | 24 | Competing-writer entry offset |
| injWord | input | 2 | Word of the entry written by the competing writer |
| injData | input | 64 | Competing-writer data |

## Verification
Every read result is registered, so it is due on regRdata exactly one cycle after the read request. The scoreboard takes its expected value from the queue at the falling edge that follows that rising edge. Effects of writes, commits and injected writes (stored contents, staging, conflict flag, armed state) cannot be seen directly. Each is observed by a later status or data read, which is issued only after the cycle in which the earlier write was registered. Expected values come from the requirements: the field positions in R2, commit merging in R5, discarding in R6, and light-mode overwrite in R7.

// File: rtl/entry_watch_pkg.sv
package entry_watch_pkg;
  localparam int DATA_W = 64;
  localparam int WORDS  = 4;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int ADDR_W = 3;
  localparam int BLK_W  = 4;
  localparam int OFFS_W = 24;
  localparam int CONF_BIT = 63;
  localparam int FULL_BIT = 55;
  localparam int BLK_LSB  = 32;
  localparam int OFFS_LSB = 0;
  localparam logic [ADDR_W-1:0] A_SPEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA0 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(1 + WORDS - 1);

  typedef enum logic [1:0] {RD_STATUS, RD_FRESH, RD_STAGE, RD_ZERO} rdSel_e;

  typedef struct packed {
    logic              loadStage;
    logic              clearStage;
    logic              writeStage;
    logic [WIDX_W-1:0] stageIdx;
    logic              commit;
    rdSel_e            rdSel;
  } strobes_t;

  function automatic int unsigned flatIdx(input int unsigned blk, input int unsigned off,
                                          input int unsigned entries);
    return blk * entries + off;
  endfunction
endpackage

// File: rtl/watch_ctrl.sv
module watch_ctrl import entry_watch_pkg::*; #(
  parameter int NUM_BLOCKS = 4,
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_BLOCKS * ENTRIES),
  localparam int OFF_IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BLK_W-1:0]  specBlock,
  input  logic [OFFS_W-1:0] specOffs,
  input  logic              specFull,
  input  logic              injWe,
  input  logic [BLK_W-1:0]  injBlock,
  input  logic [OFFS_W-1:0] injOffs,
  output strobes_t          stb,
  output logic [IDX_W-1:0]  entryIdx,
  output logic              armed,
  output logic [DATA_W-1:0] statusWord
);
  logic [BLK_W-1:0]  blockId;
  logic [OFFS_W-1:0] offs;
  logic fullMode, conflict;
  logic entryOk, specWr, dataRd0, dataWr0, dataWrN, injHit, commitOk;

  assign entryOk  = (32'(blockId) < NUM_BLOCKS) && (32'(offs) < ENTRIES);
  assign entryIdx = IDX_W'(flatIdx(32'(blockId), 32'(offs[OFF_IDX_W-1:0]), ENTRIES));

  assign specWr  = regWe && (regAddr == A_SPEC);
  assign dataRd0 = regRe && (regAddr == A_DATA0);
  assign dataWr0 = regWe && (regAddr == A_DATA0);
  assign dataWrN = regWe && (regAddr > A_DATA0) && (regAddr <= A_LAST);

  // a competing write in the arming cycle also counts, so staging never holds stale data unnoticed
  assign injHit   = fullMode && injWe && (injBlock == blockId) && (injOffs == offs) &&
                    (armed || (dataRd0 && entryOk));
  assign commitOk = dataWr0 && armed && entryOk && !conflict && !injHit;

  always_comb begin
    stb = '0;
    stb.loadStage  = dataRd0 && entryOk;
    stb.clearStage = specWr;
    stb.writeStage = dataWrN;
    stb.stageIdx   = WIDX_W'(regAddr - A_DATA0);
    stb.commit     = commitOk;
    stb.rdSel      = RD_STATUS;
    if (regRe) begin
      if (regAddr == A_SPEC)                         stb.rdSel = RD_STATUS;
      else if (dataRd0)                              stb.rdSel = entryOk ? RD_FRESH : RD_ZERO;
      else if (regAddr <= A_LAST)                    stb.rdSel = RD_STAGE;
      else                                           stb.rdSel = RD_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockId  <= '0;
      offs     <= '0;
      fullMode <= 1'b0;
      conflict <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (injHit) conflict <= 1'b1;
      if (stb.loadStage) armed <= 1'b1;
      if (dataWr0) begin
        armed <= 1'b0;
        if (!commitOk) conflict <= 1'b1;
      end
      if (specWr) begin
        blockId  <= specBlock;
        offs     <= specOffs;
        fullMode <= specFull;
        conflict <= 1'b0;
        armed    <= 1'b0;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[CONF_BIT] = conflict;
    statusWord[FULL_BIT] = fullMode;
    statusWord[BLK_LSB +: BLK_W]   = blockId;
    statusWord[OFFS_LSB +: OFFS_W] = offs;
  end
endmodule

// File: rtl/watch_datapath.sv
module watch_datapath import entry_watch_pkg::*; (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                stb,
  input  logic [DATA_W-1:0]       regWdata,
  input  logic [DATA_W-1:0]       statusWord,
  input  logic [WORDS*DATA_W-1:0] storeRd,
  output logic [WORDS*DATA_W-1:0] commitEntry,
  output logic                    storeWe,
  output logic                    storeFill,
  output logic [DATA_W-1:0]       regRdata
);
  logic [DATA_W-1:0] stage [WORDS];

  assign storeWe   = stb.commit;
  assign storeFill = stb.loadStage;

  for (genvar w = 0; w < WORDS; w++) begin : g_merge
    if (w == 0) begin : g_first
      assign commitEntry[w*DATA_W +: DATA_W] = regWdata;
    end else begin : g_rest
      assign commitEntry[w*DATA_W +: DATA_W] = stage[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) stage[w] <= '0;
      regRdata <= '0;
    end else begin
      if (stb.clearStage) begin
        for (int w = 0; w < WORDS; w++) stage[w] <= '0;
      end else if (stb.loadStage) begin
        for (int w = 0; w < WORDS; w++) stage[w] <= storeRd[w*DATA_W +: DATA_W];
      end else if (stb.writeStage) begin
        stage[stb.stageIdx] <= regWdata;
      end
      case (stb.rdSel)
        RD_STATUS: regRdata <= statusWord;
        RD_FRESH:  regRdata <= storeRd[DATA_W-1:0];
        RD_STAGE:  regRdata <= stage[stb.stageIdx];
        default:   regRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/entry_store.sv
module entry_store import entry_watch_pkg::*; #(
  parameter int NUM_BLOCKS = 4,
  parameter int ENTRIES = 8,
  parameter int CACHE_LINES = 4,
  localparam int DEPTH = NUM_BLOCKS * ENTRIES,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LINE_W = $clog2(CACHE_LINES),
  localparam int TAG_W = IDX_W - LINE_W,
  localparam int OFF_IDX_W = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [IDX_W-1:0]        rdIdx,
  input  logic                    fill,
  output logic [WORDS*DATA_W-1:0] rdEntry,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [WORDS*DATA_W-1:0] wrEntry,
  input  logic                    injWe,
  input  logic [BLK_W-1:0]        injBlock,
  input  logic [OFFS_W-1:0]       injOffs,
  input  logic [WIDX_W-1:0]       injWord,
  input  logic [DATA_W-1:0]       injData
);
  logic [WORDS*DATA_W-1:0] mem [DEPTH];
  logic [WORDS*DATA_W-1:0] lineData [CACHE_LINES];
  logic [TAG_W-1:0]        lineTag [CACHE_LINES];
  logic [CACHE_LINES-1:0]  lineVld;
  logic [LINE_W-1:0]       rdSlot;
  logic                    hit, injOk;
  logic [IDX_W-1:0]        injIdx;

  assign rdSlot  = rdIdx[LINE_W-1:0];
  assign hit     = lineVld[rdSlot] && (lineTag[rdSlot] == rdIdx[IDX_W-1:LINE_W]);
  assign rdEntry = hit ? lineData[rdSlot] : mem[rdIdx];
  assign injOk   = (32'(injBlock) < NUM_BLOCKS) && (32'(injOffs) < ENTRIES);
  assign injIdx  = IDX_W'(flatIdx(32'(injBlock), 32'(injOffs[OFF_IDX_W-1:0]), ENTRIES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int l = 0; l < CACHE_LINES; l++) begin
        lineData[l] <= '0;
        lineTag[l]  <= '0;
      end
      lineVld <= '0;
    end else begin
      if (fill && !hit) begin
        lineVld[rdSlot]  <= 1'b1;
        lineTag[rdSlot]  <= rdIdx[IDX_W-1:LINE_W];
        lineData[rdSlot] <= mem[rdIdx];
      end
      // writes go to the backing array and drop the slot; placed after the fill so they win
      if (injWe && injOk) begin
        mem[injIdx][injWord*DATA_W +: DATA_W] <= injData;
        lineVld[injIdx[LINE_W-1:0]] <= 1'b0;
      end
      if (wrEn) begin
        mem[wrIdx] <= wrEntry;
        lineVld[wrIdx[LINE_W-1:0]] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/entry_watch_top.sv
module entry_watch_top import entry_watch_pkg::*; #(
  parameter int NUM_BLOCKS = 4,
  parameter int ENTRIES = 8,
  parameter int CACHE_LINES = 4,
  localparam int IDX_W = $clog2(NUM_BLOCKS * ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              injWe,
  input  logic [BLK_W-1:0]  injBlock,
  input  logic [OFFS_W-1:0] injOffs,
  input  logic [WIDX_W-1:0] injWord,
  input  logic [DATA_W-1:0] injData
);
  strobes_t                stb;
  logic [IDX_W-1:0]        entryIdx;
  logic                    armed, storeWe, storeFill;
  logic [DATA_W-1:0]       statusWord;
  logic [WORDS*DATA_W-1:0] storeRd, commitEntry;

  watch_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .specBlock(regWdata[BLK_LSB +: BLK_W]), .specOffs(regWdata[OFFS_LSB +: OFFS_W]),
    .specFull(regWdata[FULL_BIT]), .injWe(injWe), .injBlock(injBlock), .injOffs(injOffs),
    .stb(stb), .entryIdx(entryIdx), .armed(armed), .statusWord(statusWord));

  watch_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata), .statusWord(statusWord),
    .storeRd(storeRd), .commitEntry(commitEntry), .storeWe(storeWe), .storeFill(storeFill),
    .regRdata(regRdata));

  entry_store #(.NUM_BLOCKS(NUM_BLOCKS), .ENTRIES(ENTRIES), .CACHE_LINES(CACHE_LINES)) i_store (
    .clk(clk), .rstN(rstN), .rdIdx(entryIdx), .fill(storeFill), .rdEntry(storeRd),
    .wrEn(storeWe), .wrIdx(entryIdx), .wrEntry(commitEntry), .injWe(injWe),
    .injBlock(injBlock), .injOffs(injOffs), .injWord(injWord), .injData(injData));
endmodule

// File: rtl/watch_checker.sv
module watch_checker import entry_watch_pkg::*; (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              injWe,
  input logic [BLK_W-1:0]  injBlock,
  input logic [OFFS_W-1:0] injOffs,
  input logic              conflictFlag,
  input logic              fullFlag,
  input logic [BLK_W-1:0]  watchBlk,
  input logic [OFFS_W-1:0] watchOffs,
  input logic              armed
);
  logic specWr, commitWr;
  assign specWr   = regWe && (regAddr == A_SPEC);
  assign commitWr = regWe && (regAddr == A_DATA0);

  // R9
  spec_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    specWr |=> !conflictFlag && !armed);

  // R8
  bad_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitWr && !armed |=> conflictFlag);

  // R11
  commit_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitWr |=> !armed);

  // R6
  inj_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && fullFlag && injWe && injBlock == watchBlk && injOffs == watchOffs && !specWr
    |=> conflictFlag);

  // R7
  light_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fullFlag && !conflictFlag && !commitWr |=> !conflictFlag);
endmodule

bind entry_watch_top watch_checker i_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .injWe(injWe),
  .injBlock(injBlock), .injOffs(injOffs),
  .conflictFlag(statusWord[entry_watch_pkg::CONF_BIT]),
  .fullFlag(statusWord[entry_watch_pkg::FULL_BIT]),
  .watchBlk(statusWord[entry_watch_pkg::BLK_LSB +: entry_watch_pkg::BLK_W]),
  .watchOffs(statusWord[entry_watch_pkg::OFFS_LSB +: entry_watch_pkg::OFFS_W]),
  .armed(armed));

// File: tb/test_entry_watch_top.sv
`timescale 1ns/1ps
module test_entry_watch_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        injWe = 1'b0;
  logic [3:0]  injBlock = '0;
  logic [23:0] injOffs = '0;
  logic [1:0]  injWord = '0;
  logic [63:0] injData = '0;

  int checks = 0, errors = 0;
  logic        pendRd = 1'b0;
  logic        finished = 1'b0;
  logic [63:0] expQ[$];
  string       tagQ[$];

  localparam logic [2:0]  SPEC = 3'd0, D0 = 3'd1, D1 = 3'd2, D2 = 3'd3, D3 = 3'd4;
  localparam logic [63:0] CONF = 64'h8000_0000_0000_0000;

  entry_watch_top i_entry_watch_top (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .injWe(injWe), .injBlock(injBlock),
    .injOffs(injOffs), .injWord(injWord), .injData(injData));

  always #2.5 clk = ~clk;

  function automatic logic [63:0] mk(input logic full, input logic [3:0] blk, input logic [23:0] off);
    return {1'b0, 7'b0, full, 19'b0, blk, 8'b0, off};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); regRe = 1'b1; regAddr = a;
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic inj(input logic [3:0] b, input logic [23:0] o, input logic [1:0] w, input logic [63:0] d);
    @(negedge clk); injWe = 1'b1; injBlock = b; injOffs = o; injWord = w; injData = d;
    @(negedge clk); injWe = 1'b0;
  endtask

  always @(posedge clk) pendRd <= regRe;

  // monitor: one registered result per read request
  always @(negedge clk) begin
    if (pendRd && !finished) begin
      logic [63:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (regRdata !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, regRdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    rd(SPEC, 64'h0, "R1 status after reset");
    wr(SPEC, mk(1, 4'd1, 24'd3));
    rd(SPEC, mk(1, 4'd1, 24'd3), "R2 selection fields read back");
    rd(D0, 64'h0, "R1 entry zero after reset");
    wr(D1, 64'hA1); wr(D2, 64'hA2); wr(D3, 64'hA3);
    rd(D1, 64'hA1, "R3 staged word1 read");
    wr(D0, 64'hA0);
    rd(SPEC, mk(1, 4'd1, 24'd3), "R5 clean commit keeps conflict clear");
    rd(D0, 64'hA0, "R5 committed word0");
    rd(D3, 64'hA3, "R5 committed word3");
    wr(SPEC, mk(1, 4'd0, 24'd3));
    rd(D0, 64'h0, "R12 slot-sharing entry reads own contents");
    wr(SPEC, mk(1, 4'd1, 24'd3));
    rd(D0, 64'hA0, "R12 original entry after alias load");
    wr(D2, 64'hB2);
    rd(D2, 64'hB2, "R4 staging write visible");
    wr(SPEC, mk(1, 4'd1, 24'd3));
    rd(D2, 64'h0, "R9 staging cleared by selection write");
    rd(D0, 64'hA0, "R3 reload word0");
    rd(D2, 64'hA2, "R4 staging write not in store");
    // full-mode conflict
    wr(SPEC, mk(1, 4'd2, 24'd5));
    rd(D0, 64'h0, "R3 load empty entry");
    wr(D1, 64'hC1);
    inj(4'd2, 24'd5, 2'd1, 64'h5A5A);
    wr(D0, 64'hC0);
    rd(SPEC, CONF | mk(1, 4'd2, 24'd5), "R6 conflict flagged");
    wr(SPEC, mk(1, 4'd2, 24'd5));
    rd(SPEC, mk(1, 4'd2, 24'd5), "R9 conflict cleared");
    rd(D0, 64'h0, "R6 commit discarded");
    rd(D1, 64'h5A5A, "R6 injected word kept");
    // other-entry write
    inj(4'd2, 24'd6, 2'd1, 64'h77);
    wr(D0, 64'hD0);
    rd(SPEC, mk(1, 4'd2, 24'd5), "R10 other-entry write no conflict");
    rd(D0, 64'hD0, "R10 commit applied");
    rd(D1, 64'h5A5A, "R10 word1 kept from reload");
    wr(SPEC, mk(1, 4'd2, 24'd6));
    rd(D0, 64'h0, "R10 other entry word0");
    rd(D1, 64'h77, "R10 injected word in other entry");
    // light mode
    wr(SPEC, mk(0, 4'd3, 24'd7));
    rd(D0, 64'h0, "R3 light load");
    inj(4'd3, 24'd7, 2'd2, 64'h99);
    wr(D0, 64'hE0);
    rd(SPEC, mk(0, 4'd3, 24'd7), "R7 light mode no conflict");
    rd(D0, 64'hE0, "R7 light commit applied");
    rd(D2, 64'h0, "R7 injected word overwritten by staging");
    // commit ends the watch
    wr(SPEC, mk(1, 4'd0, 24'd0));
    rd(D0, 64'h0, "R3 load for end-of-watch case");
    wr(D0, 64'hF0);
    wr(D0, 64'hF1);
    rd(SPEC, CONF | mk(1, 4'd0, 24'd0), "R11 second commit rejected");
    rd(D0, 64'hF0, "R11 entry holds first commit");
    // invalid commits
    wr(SPEC, mk(1, 4'd0, 24'd1));
    wr(D0, 64'h1234);
    rd(SPEC, CONF | mk(1, 4'd0, 24'd1), "R8 commit without load");
    rd(D0, 64'h0, "R8 entry untouched");
    wr(SPEC, mk(1, 4'd5, 24'd0));
    rd(D0, 64'h0, "R8 bad block reads zero");
    wr(D0, 64'h1234);
    rd(SPEC, CONF | mk(1, 4'd5, 24'd0), "R8 bad block commit");
    wr(SPEC, mk(1, 4'd1, 24'd9));
    rd(D0, 64'h0, "R8 bad offset reads zero");
    wr(D0, 64'h1234);
    rd(SPEC, CONF | mk(1, 4'd1, 24'd9), "R8 bad offset commit");
    wr(SPEC, mk(1, 4'd1, 24'd1));
    rd(D0, 64'h0, "R8 low-bit alias entry untouched");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      if (expQ.size() != 0) begin
        errors++;
        $display("FAIL R3 read results missing: actual %0d pending expected 0", expQ.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule